// File: doc/BRIEF.md
# SPI Register-Access Slave for a CAN Controller Host Port

This block is the host-side front end of a CAN controller. An external host talks to it over an SPI link in mode 0, so the link idles low, the host samples on the rising clock edge and the slave changes its output on the falling edge. Each chip-select frame starts with a one-byte opcode, sent most significant bit first. The opcode selects one of four kinds of operation:

- a configuration-register write, where the next byte carries the value;
- a register read, where the value comes back during the second byte;
- a byte stream into the transmit FIFO or out of the receive FIFO;
- a single-byte command that restores the register defaults.

The block holds the configuration registers: operating mode, transmit configuration, interrupt mask and two bit-timing bytes. It also holds a status register that the core loads, plus interrupt-flag and error-flag registers. Both flag registers gather set pulses from the core and clear the bits that a host read returned. The core sees every configuration register as a parallel output. The FIFO storage lives outside the block and is reached only through push and pop strobes with byte-wide data. All SPI inputs are synchronised into the system clock domain and their edges are detected there. The SPI clock must therefore be several times slower than the system clock.

Top module: `canSpiRegIf`

## Requirements
- R1: After rstN the mode register reads 0x80, meaning mode field bits 7:5 = 4 (init). The status register reads 0x82. The transmit-configuration, interrupt-mask and both timing registers are 0x00.
- R2: A two-byte frame whose opcode is 0x14 (mode), 0x16 (transmit config), 0x1C (interrupt mask), 0x18 (timing A) or 0x1A (timing B) loads the second byte into that register and its output port.
- R3: A read frame returns the selected value MSB first during the second byte. The read opcodes are 0xD2 mode, 0xD4 transmit config, 0xD6 timing A, 0xD8 timing B, 0xE2 status, 0xDA message status, 0xEA receive error count and 0xEC transmit error count.
- R4: The interrupt-flag register (read opcode 0xDE) ORs in intSet pulses. A read clears only the bits it returned, so a bit set while the read is in progress survives.
- R5: The error-flag register (read opcode 0xDC) ORs in errSet pulses and clears the returned bits on read. The 0x56 command does not clear it.
- R6: Opcode 0x56 is complete after one byte. It pulses coreReset for exactly one clock and restores the R1 values of all registers except the error flags, after which ctrlMode reads 4.
- R7: In a 0x12 frame, each complete byte after the opcode produces one txPush carrying that byte, up to 13 bytes. Any further bytes are dropped.
- R8: In a 0x48 frame the block pops the receive FIFO 14 times. Data byte n shifts out the rxData value present at pop n. Bytes after the 14th shift out 0x00.
- R9: An unknown opcode shifts out 0x00 and ignores any bytes that follow. No register changes and no FIFO strobe is produced.
- R10: Raising chip select in the middle of a byte aborts the frame. No register update, reset command or FIFO strobe results from the partial byte.
- R11: A statLoad pulse copies statIn into the status register.
- R12: ctrlMode is bits 7:5 of the mode register and txEnable is bit 7 of the transmit-configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous-free synchronous reset |
| spiSclk | input | 1 | SPI serial clock (mode 0) |
| spiCsN | input | 1 | SPI chip select, active low |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host |
| statLoad | input | 1 | Load strobe for the status register |
| statIn | input | 8 | Status value from the core |
| intSet | input | 8 | Interrupt-flag set pulses |
| errSet | input | 8 | Error-flag set pulses |
| msgStatIn | input | 8 | Message status value from the core |
| recIn | input | 8 | Receive error count from the core |
| tecIn | input | 8 | Transmit error count from the core |
| rxData | input | 8 | Head byte of the receive FIFO (show-ahead) |
| modeReg | output | 8 | Mode register |
| txCfgReg | output | 8 | Transmit-configuration register |
| intMaskReg | output | 8 | Interrupt-mask register |
| timAReg | output | 8 | Timing register A |
| timBReg | output | 8 | Timing register B |
| ctrlMode | output | 3 | Operating mode field |
| txEnable | output | 1 | Transmit enable |
| coreReset | output | 1 | One-clock pulse from the reset command |
| txPush | output | 1 | Transmit FIFO push strobe |
| txData | output | 8 | Byte pushed into the transmit FIFO |
| rxPop | output | 1 | Receive FIFO pop strobe |

## Verification
Each SPI input passes through two synchroniser flops and one edge-detect flop before the control logic acts on it. A completed byte therefore turns into a strobe about four clocks after its last rising SCLK edge, and register ports and FIFO strobes follow one clock after that. MISO settles about three clocks after the falling SCLK edge that moves it. The bench holds each SCLK half period for eight system clocks and samples MISO at the end of the low half, just before it raises SCLK. Register ports and FIFO logs are checked only after chip select has been high for four further half periods, which is long after every pending strobe has landed.

// File: rtl/canSpiRegPkg.sv
package canSpiRegPkg;

  localparam logic [7:0] OP_RESET      = 8'h56;
  localparam logic [7:0] OP_WR_MODE    = 8'h14;
  localparam logic [7:0] OP_WR_TXCFG   = 8'h16;
  localparam logic [7:0] OP_WR_INTMASK = 8'h1C;
  localparam logic [7:0] OP_WR_TIMA    = 8'h18;
  localparam logic [7:0] OP_WR_TIMB    = 8'h1A;
  localparam logic [7:0] OP_RD_MODE    = 8'hD2;
  localparam logic [7:0] OP_RD_TXCFG   = 8'hD4;
  localparam logic [7:0] OP_RD_STAT    = 8'hE2;
  localparam logic [7:0] OP_RD_INTF    = 8'hDE;
  localparam logic [7:0] OP_RD_ERR     = 8'hDC;
  localparam logic [7:0] OP_RD_TIMA    = 8'hD6;
  localparam logic [7:0] OP_RD_TIMB    = 8'hD8;
  localparam logic [7:0] OP_RD_MSG     = 8'hDA;
  localparam logic [7:0] OP_RD_REC     = 8'hEA;
  localparam logic [7:0] OP_RD_TEC     = 8'hEC;
  localparam logic [7:0] OP_TX_FIFO    = 8'h12;
  localparam logic [7:0] OP_RX_FIFO    = 8'h48;

  localparam logic [7:0] MODE_RESET = 8'h80;
  localparam logic [7:0] STAT_RESET = 8'h82;

  typedef enum logic [2:0] {
    PH_OPCODE, PH_WRITE, PH_READ, PH_TXFIFO, PH_RXFIFO, PH_IGNORE
  } phase_e;

  // Strobes from the serial control to the register datapath
  typedef struct packed {
    logic       regWrite;
    logic       rdCommit;
    logic       masterReset;
    logic       fifoPush;
    logic       fifoPop;
    logic [7:0] opcode;
    logic [7:0] data;
    logic [7:0] snap;
  } ctlStrobe_t;

  function automatic logic isWriteOp(input logic [7:0] op);
    return op inside {OP_WR_MODE, OP_WR_TXCFG, OP_WR_INTMASK, OP_WR_TIMA, OP_WR_TIMB};
  endfunction

  function automatic logic isReadOp(input logic [7:0] op);
    return op inside {OP_RD_MODE, OP_RD_TXCFG, OP_RD_STAT, OP_RD_INTF, OP_RD_ERR,
                      OP_RD_TIMA, OP_RD_TIMB, OP_RD_MSG, OP_RD_REC, OP_RD_TEC};
  endfunction

endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import canSpiRegPkg::*;
#(
  parameter int RxFrameBytes = 14,
  parameter int TxFrameBytes = 13,
  parameter int SyncStages   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       mosi,
  input  logic [7:0] rdValue,
  input  logic [7:0] rxData,
  output logic [7:0] lookupOp,
  output logic       miso,
  output ctlStrobe_t strobe
);

  localparam int MaxBytes = (RxFrameBytes > TxFrameBytes) ? RxFrameBytes : TxFrameBytes;
  localparam int IdxW     = $clog2(MaxBytes + 1);
  localparam logic [IdxW-1:0] RxLim = IdxW'(RxFrameBytes);
  localparam logic [IdxW-1:0] TxLim = IdxW'(TxFrameBytes);

  logic [SyncStages:0]   sclkQ;
  logic [SyncStages-1:0] csQ;
  logic [SyncStages-1:0] mosiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= '0;
      csQ   <= '1;
      mosiQ <= '0;
    end else begin
      sclkQ <= {sclkQ[SyncStages-1:0], sclk};
      csQ   <= {csQ[SyncStages-2:0], csN};
      mosiQ <= {mosiQ[SyncStages-2:0], mosi};
    end
  end

  logic sclkRise, sclkFall, csActive, mosiBit;
  assign sclkRise = sclkQ[SyncStages-1] & ~sclkQ[SyncStages];
  assign sclkFall = ~sclkQ[SyncStages-1] & sclkQ[SyncStages];
  assign csActive = ~csQ[SyncStages-1];
  assign mosiBit  = mosiQ[SyncStages-1];

  phase_e          phase;
  logic [2:0]      bitCnt;
  logic [6:0]      inShift;
  logic [7:0]      outShift;
  logic            skipShift;
  logic [7:0]      opcodeReg;
  logic [7:0]      snapReg;
  logic [IdxW-1:0] byteIdx;
  logic [7:0]      byteIn;

  assign byteIn   = {inShift, mosiBit};
  assign lookupOp = byteIn;
  assign miso     = csActive & outShift[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_OPCODE;
      bitCnt    <= '0;
      inShift   <= '0;
      outShift  <= '0;
      skipShift <= 1'b0;
      opcodeReg <= '0;
      snapReg   <= '0;
      byteIdx   <= '0;
      strobe    <= '0;
    end else begin
      strobe <= '0;
      if (!csActive) begin
        phase     <= PH_OPCODE;
        bitCnt    <= '0;
        outShift  <= '0;
        skipShift <= 1'b0;
        byteIdx   <= '0;
      end else if (sclkRise) begin
        inShift <= byteIn[6:0];
        bitCnt  <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          skipShift <= 1'b1;
          outShift  <= 8'h00;
          phase     <= PH_IGNORE;
          case (phase)
            PH_OPCODE: begin
              opcodeReg <= byteIn;
              if (byteIn == OP_RESET) begin
                strobe.masterReset <= 1'b1;
              end else if (isWriteOp(byteIn)) begin
                phase <= PH_WRITE;
              end else if (isReadOp(byteIn)) begin
                phase    <= PH_READ;
                outShift <= rdValue;
                snapReg  <= rdValue;
              end else if (byteIn == OP_TX_FIFO) begin
                phase   <= PH_TXFIFO;
                byteIdx <= '0;
              end else if (byteIn == OP_RX_FIFO) begin
                phase          <= PH_RXFIFO;
                outShift       <= rxData;
                strobe.fifoPop <= 1'b1;
                byteIdx        <= IdxW'(1);
              end
            end
            PH_WRITE: begin
              strobe.regWrite <= 1'b1;
              strobe.opcode   <= opcodeReg;
              strobe.data     <= byteIn;
            end
            PH_READ: begin
              strobe.rdCommit <= 1'b1;
              strobe.opcode   <= opcodeReg;
              strobe.snap     <= snapReg;
            end
            PH_TXFIFO: begin
              phase <= PH_TXFIFO;
              if (byteIdx < TxLim) begin
                strobe.fifoPush <= 1'b1;
                strobe.data     <= byteIn;
                byteIdx         <= byteIdx + IdxW'(1);
              end
            end
            PH_RXFIFO: begin
              phase <= PH_RXFIFO;
              if (byteIdx < RxLim) begin
                strobe.fifoPop <= 1'b1;
                outShift       <= rxData;
                byteIdx        <= byteIdx + IdxW'(1);
              end
            end
            default: ;
          endcase
        end
      end else if (sclkFall) begin
        if (skipShift) skipShift <= 1'b0;
        else           outShift  <= {outShift[6:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spiRegData.sv
module spiRegData
  import canSpiRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic [7:0] lookupOp,
  input  logic       statLoad,
  input  logic [7:0] statIn,
  input  logic [7:0] intSet,
  input  logic [7:0] errSet,
  input  logic [7:0] msgStatIn,
  input  logic [7:0] recIn,
  input  logic [7:0] tecIn,
  output logic [7:0] rdValue,
  output logic [7:0] modeReg,
  output logic [7:0] txCfgReg,
  output logic [7:0] intMaskReg,
  output logic [7:0] timAReg,
  output logic [7:0] timBReg,
  output logic       coreReset,
  output logic       txPush,
  output logic [7:0] txData,
  output logic       rxPop
);

  logic [7:0] statReg, intFlags, errFlags;
  logic [7:0] intClr, errClr;

  assign intClr = (strobe.rdCommit && strobe.opcode == OP_RD_INTF) ? strobe.snap : 8'h00;
  assign errClr = (strobe.rdCommit && strobe.opcode == OP_RD_ERR)  ? strobe.snap : 8'h00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg    <= MODE_RESET;
      txCfgReg   <= '0;
      intMaskReg <= '0;
      timAReg    <= '0;
      timBReg    <= '0;
      statReg    <= STAT_RESET;
      intFlags   <= '0;
    end else if (strobe.masterReset) begin
      modeReg    <= MODE_RESET;
      txCfgReg   <= '0;
      intMaskReg <= '0;
      timAReg    <= '0;
      timBReg    <= '0;
      statReg    <= STAT_RESET;
      intFlags   <= intSet;
    end else begin
      if (strobe.regWrite) begin
        case (strobe.opcode)
          OP_WR_MODE:    modeReg    <= strobe.data;
          OP_WR_TXCFG:   txCfgReg   <= strobe.data;
          OP_WR_INTMASK: intMaskReg <= strobe.data;
          OP_WR_TIMA:    timAReg    <= strobe.data;
          OP_WR_TIMB:    timBReg    <= strobe.data;
          default: ;
        endcase
      end
      if (statLoad) statReg <= statIn;
      intFlags <= (intFlags & ~intClr) | intSet;
    end
  end

  // Error flags survive the reset command; only rstN clears them
  always_ff @(posedge clk) begin
    if (!rstN) errFlags <= '0;
    else       errFlags <= (errFlags & ~errClr) | errSet;
  end

  always_comb begin
    case (lookupOp)
      OP_RD_MODE:  rdValue = modeReg;
      OP_RD_TXCFG: rdValue = txCfgReg;
      OP_RD_STAT:  rdValue = statReg;
      OP_RD_INTF:  rdValue = intFlags;
      OP_RD_ERR:   rdValue = errFlags;
      OP_RD_TIMA:  rdValue = timAReg;
      OP_RD_TIMB:  rdValue = timBReg;
      OP_RD_MSG:   rdValue = msgStatIn;
      OP_RD_REC:   rdValue = recIn;
      OP_RD_TEC:   rdValue = tecIn;
      default:     rdValue = 8'h00;
    endcase
  end

  assign coreReset = strobe.masterReset;
  assign txPush    = strobe.fifoPush;
  assign txData    = strobe.data;
  assign rxPop     = strobe.fifoPop;

endmodule

// File: rtl/canSpiRegIf.sv
module canSpiRegIf
  import canSpiRegPkg::*;
#(
  parameter int RxFrameBytes = 14,
  parameter int TxFrameBytes = 13,
  parameter int SyncStages   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiSclk,
  input  logic       spiCsN,
  input  logic       spiMosi,
  output logic       spiMiso,
  input  logic       statLoad,
  input  logic [7:0] statIn,
  input  logic [7:0] intSet,
  input  logic [7:0] errSet,
  input  logic [7:0] msgStatIn,
  input  logic [7:0] recIn,
  input  logic [7:0] tecIn,
  input  logic [7:0] rxData,
  output logic [7:0] modeReg,
  output logic [7:0] txCfgReg,
  output logic [7:0] intMaskReg,
  output logic [7:0] timAReg,
  output logic [7:0] timBReg,
  output logic [2:0] ctrlMode,
  output logic       txEnable,
  output logic       coreReset,
  output logic       txPush,
  output logic [7:0] txData,
  output logic       rxPop
);

  ctlStrobe_t strobe;
  logic [7:0] lookupOp, rdValue;

  spiRegCtrl #(
    .RxFrameBytes(RxFrameBytes),
    .TxFrameBytes(TxFrameBytes),
    .SyncStages  (SyncStages)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sclk(spiSclk), .csN(spiCsN), .mosi(spiMosi),
    .rdValue(rdValue), .rxData(rxData), .lookupOp(lookupOp),
    .miso(spiMiso), .strobe(strobe)
  );

  spiRegData data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupOp(lookupOp),
    .statLoad(statLoad), .statIn(statIn), .intSet(intSet), .errSet(errSet),
    .msgStatIn(msgStatIn), .recIn(recIn), .tecIn(tecIn), .rdValue(rdValue),
    .modeReg(modeReg), .txCfgReg(txCfgReg), .intMaskReg(intMaskReg),
    .timAReg(timAReg), .timBReg(timBReg), .coreReset(coreReset),
    .txPush(txPush), .txData(txData), .rxPop(rxPop)
  );

  assign ctrlMode = modeReg[7:5];
  assign txEnable = txCfgReg[7];

endmodule

// File: rtl/canSpiRegIf_chk.sv
module canSpiRegIf_chk #(
  parameter int RxFrameBytes = 14,
  parameter int TxFrameBytes = 13
) (
  input logic       clk,
  input logic       rstN,
  input logic       spiCsN,
  input logic       coreReset,
  input logic [2:0] ctrlMode,
  input logic       txPush,
  input logic       rxPop
);

  logic [7:0] popCnt, pushCnt;

  always_ff @(posedge clk) begin
    if (!rstN || spiCsN) begin
      popCnt  <= '0;
      pushCnt <= '0;
    end else begin
      if (rxPop  && popCnt  != 8'hFF) popCnt  <= popCnt + 8'd1;
      if (txPush && pushCnt != 8'hFF) pushCnt <= pushCnt + 8'd1;
    end
  end

  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |=> !coreReset);  // R6
  AST_MODE_INIT_AFTER_CMD: assert property (@(posedge clk) disable iff (!rstN)
    coreReset |=> (ctrlMode == 3'd4));  // R6
  AST_FIFO_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txPush, rxPop}));  // R7
  AST_POP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    popCnt <= 8'(RxFrameBytes));  // R8
  AST_PUSH_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    pushCnt <= 8'(TxFrameBytes));  // R7

endmodule

bind canSpiRegIf canSpiRegIf_chk #(
  .RxFrameBytes(RxFrameBytes),
  .TxFrameBytes(TxFrameBytes)
) chk_i (
  .clk(clk), .rstN(rstN), .spiCsN(spiCsN), .coreReset(coreReset),
  .ctrlMode(ctrlMode), .txPush(txPush), .rxPop(rxPop)
);

// File: tb/canSpiRegIf_tb_top.sv
module canSpiRegIf_tb_top;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiSclk = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic spiMiso;
  logic statLoad = 1'b0;
  logic [7:0] statIn = '0, intSet = '0, errSet = '0;
  logic [7:0] msgStatIn = '0, recIn = '0, tecIn = '0;
  logic [7:0] rxData;
  logic [7:0] modeReg, txCfgReg, intMaskReg, timAReg, timBReg, txData;
  logic [2:0] ctrlMode;
  logic txEnable, coreReset, txPush, rxPop;

  always #2.5 clk = ~clk;

  canSpiRegIf dut_i (
    .clk(clk), .rstN(rstN), .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .statLoad(statLoad), .statIn(statIn), .intSet(intSet),
    .errSet(errSet), .msgStatIn(msgStatIn), .recIn(recIn), .tecIn(tecIn),
    .rxData(rxData), .modeReg(modeReg), .txCfgReg(txCfgReg), .intMaskReg(intMaskReg),
    .timAReg(timAReg), .timBReg(timBReg), .ctrlMode(ctrlMode), .txEnable(txEnable),
    .coreReset(coreReset), .txPush(txPush), .txData(txData), .rxPop(rxPop)
  );

  int errors = 0, checks = 0;
  logic [7:0] txBuf [0:15];
  logic [7:0] rxBuf [0:15];
  logic [7:0] rxMem [0:15];
  logic [7:0] txLog [0:31];
  logic [7:0] shadow [0:4];
  int txCnt = 0, rxIdx = 0, rstCnt = 0;

  assign rxData = (rxIdx < 16) ? rxMem[rxIdx] : 8'h00;

  always @(posedge clk) begin
    if (txPush) begin
      if (txCnt < 32) txLog[txCnt] <= txData;
      txCnt <= txCnt + 1;
    end
    if (rxPop) rxIdx <= rxIdx + 1;
    if (coreReset) rstCnt <= rstCnt + 1;
  end

  function automatic logic [7:0] wrOp(input int i);
    case (i) 0: return 8'h14; 1: return 8'h16; 2: return 8'h1C; 3: return 8'h18; default: return 8'h1A; endcase
  endfunction
  function automatic logic [7:0] rdOp(input int i);
    case (i) 0: return 8'hD2; 1: return 8'hD4; 2: return 8'h00; 3: return 8'hD6; default: return 8'hD8; endcase
  endfunction
  function automatic logic [7:0] portVal(input int i);
    case (i) 0: return modeReg; 1: return txCfgReg; 2: return intMaskReg; 3: return timAReg; default: return timBReg; endcase
  endfunction
  function automatic logic [7:0] defVal(input int i);
    return (i == 0) ? 8'h80 : 8'h00;
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // abortBits > 0: raise chip select after that many bits of the last byte
  task automatic doFrame(input int nBytes, input int abortBits);
    int total;
    total = (abortBits > 0) ? (nBytes - 1) * 8 + abortBits : nBytes * 8;
    spiCsN = 1'b0;
    waitClk(HALF);
    for (int i = 0; i < total; i++) begin
      spiMosi = txBuf[i / 8][7 - (i % 8)];
      waitClk(HALF);
      rxBuf[i / 8][7 - (i % 8)] = spiMiso;
      spiSclk = 1'b1;
      waitClk(HALF);
      spiSclk = 1'b0;
    end
    waitClk(HALF);
    spiCsN = 1'b1;
    waitClk(4 * HALF);
  endtask

  task automatic wrReg(input logic [7:0] op, input logic [7:0] val);
    txBuf[0] = op; txBuf[1] = val;
    doFrame(2, 0);
  endtask

  task automatic rdReg(input logic [7:0] op, output logic [7:0] val);
    txBuf[0] = op; txBuf[1] = 8'h00;
    doFrame(2, 0);
    val = rxBuf[1];
  endtask

  task automatic pulseInt(input logic [7:0] v);
    intSet = v; waitClk(1); intSet = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int base;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 16; i++) rxMem[i] = 8'($urandom);
    for (int i = 0; i < 5; i++) shadow[i] = defVal(i);
    waitClk(10);
    rstN = 1'b1;
    waitClk(10);

    // R1 reset values
    rdReg(8'hD2, v); chk("R1 mode reset", v, 8'h80);
    rdReg(8'hE2, v); chk("R1 status reset", v, 8'h82);
    rdReg(8'hD4, v); chk("R1 txcfg reset", v, 8'h00);
    chk("R1 intmask port reset", intMaskReg, 8'h00);
    chk("R12 mode field init", ctrlMode, 3'd4);

    // R2 R3 R12 random writes with readback
    for (int n = 0; n < 24; n++) begin
      int idx;
      logic [7:0] val;
      idx = int'($urandom % 5);
      val = 8'($urandom);
      wrReg(wrOp(idx), val);
      shadow[idx] = val;
      chk("R2 port after write", portVal(idx), val);
      if (idx != 2) begin
        rdReg(rdOp(idx), v);
        chk("R3 readback", v, val);
      end
      chk("R12 mode field", ctrlMode, shadow[0][7:5]);
      chk("R12 tx enable", txEnable, shadow[1][7]);
    end

    // R3 core-sourced values
    msgStatIn = 8'($urandom); recIn = 8'($urandom); tecIn = 8'($urandom);
    rdReg(8'hDA, v); chk("R3 message status", v, msgStatIn);
    rdReg(8'hEA, v); chk("R3 receive count", v, recIn);
    rdReg(8'hEC, v); chk("R3 transmit count", v, tecIn);

    // R11 status load
    statIn = 8'h5C; statLoad = 1'b1; waitClk(1); statLoad = 1'b0;
    rdReg(8'hE2, v); chk("R11 status load", v, 8'h5C);

    // R4 interrupt flags: accumulate, clear on read
    pulseInt(8'h20); pulseInt(8'h01);
    rdReg(8'hDE, v); chk("R4 flags accumulate", v, 8'h21);
    rdReg(8'hDE, v); chk("R4 flags cleared", v, 8'h00);
    // set arrives during the data byte of a read: kept for the next read
    txBuf[0] = 8'hDE; txBuf[1] = 8'h00;
    fork
      doFrame(2, 0);
      begin waitClk(17 * HALF + 8); pulseInt(8'h04); end
    join
    chk("R4 read before late set", rxBuf[1], 8'h00);
    rdReg(8'hDE, v); chk("R4 late set kept", v, 8'h04);

    // R5 R6 error flags survive reset command, registers restored
    errSet = 8'h11; waitClk(1); errSet = 8'h00;
    txBuf[0] = 8'h56; doFrame(1, 0);
    chk("R6 one reset pulse", rstCnt, 1);
    for (int i = 0; i < 5; i++) begin
      shadow[i] = defVal(i);
      chk("R6 register default", portVal(i), defVal(i));
    end
    chk("R6 mode init", ctrlMode, 3'd4);
    rdReg(8'hE2, v); chk("R6 status default", v, 8'h82);
    rdReg(8'hDC, v); chk("R5 error flags kept", v, 8'h11);
    rdReg(8'hDC, v); chk("R5 error flags cleared", v, 8'h00);

    // R7 transmit FIFO stream with overflow bytes
    base = txCnt;
    txBuf[0] = 8'h12;
    for (int i = 1; i < 16; i++) txBuf[i] = 8'($urandom);
    doFrame(16, 0);
    chk("R7 push count", txCnt - base, 13);
    for (int i = 0; i < 13; i++) chk("R7 push data", txLog[base + i], txBuf[i + 1]);

    // R8 receive FIFO stream
    txBuf[0] = 8'h48;
    for (int i = 1; i < 16; i++) txBuf[i] = 8'h00;
    doFrame(16, 0);
    chk("R8 pop count", rxIdx, 14);
    for (int i = 0; i < 14; i++) chk("R8 rx byte", rxBuf[i + 1], rxMem[i]);
    chk("R8 byte after frame", rxBuf[15], 8'h00);

    // R9 unknown opcode
    wrReg(8'h18, 8'h3C); shadow[3] = 8'h3C;
    base = txCnt;
    txBuf[0] = 8'h77; txBuf[1] = 8'hAA; txBuf[2] = 8'h14;
    doFrame(3, 0);
    chk("R9 shifts zero", rxBuf[1], 8'h00);
    for (int i = 0; i < 5; i++) chk("R9 register unchanged", portVal(i), shadow[i]);
    chk("R9 no push", txCnt - base, 0);
    chk("R9 no pop", rxIdx, 14);

    // R10 aborted frames
    txBuf[0] = 8'h16; txBuf[1] = 8'h80; doFrame(2, 5);
    chk("R10 aborted write", txCfgReg, shadow[1]);
    txBuf[0] = 8'h56; doFrame(1, 6);
    chk("R10 aborted reset", rstCnt, 1);
    chk("R10 timing kept", timAReg, 8'h3C);
    base = txCnt;
    txBuf[0] = 8'h12; txBuf[1] = 8'hE7; doFrame(2, 7);
    chk("R10 aborted push", txCnt - base, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule